// File: doc/BRIEF.md
# Clock Loss-of-Signal Monitor

This block watches a single input clock for missing pulses and drives a sticky loss-of-signal alarm. The input clock first feeds a free-running divider in its own domain, which turns it into a slow square wave. A fast reference clock samples that wave through a two-flop synchronizer and counts reference cycles since the last transition, where a rising and a falling transition both count. When that count reaches twice the configured expected spacing, the block treats the input as lost.

The alarm is set on any loss condition. It falls only after a programmable number of consecutive reference cycles in which no loss condition holds. A loss condition during that window keeps the alarm set and starts the window again from zero. The divider ratio, the expected spacing and the window length are static inputs, captured while the respective reset is held.

Top module: `los_monitor`

## Requirements
- R1: While refRstN is low and afterwards, losAlarm is 1. The gap counter starts saturated, so the alarm stays set until transitions arrive and a full validation window has passed.
- R2: The divided wave toggles once every divRatio rising edges of monClk. A divRatio of 0 acts as 1.
- R3: The divided wave passes through two synchronizing flops in the reference domain. A transition is a difference between the last two synchronized samples, and rising and falling transitions count alike. Each detected transition resets the gap count to 0.
- R4: The gap count is the number of reference cycles since the last detected transition. While it is at least 2*expectCount, a loss condition holds, and losAlarm is 1 on the next reference cycle.
- R5: While the alarm is set, losAlarm goes to 0 on the cycle after validLen consecutive reference cycles without a loss condition. A validLen of 0 acts as 1. A cleared alarm rises only on a loss condition.
- R6: A loss condition inside the validation window keeps losAlarm at 1 and restarts the window count from zero.
- R7: The gap count saturates at its maximum value and does not wrap. A stopped input therefore keeps the alarm set for any length of time.
- R8: divRatio, expectCount and validLen are captured during reset. Changes made to them after reset release have no effect.
- R9: A pause in the input whose gap stays below 2*expectCount raises no alarm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| monClk | input | 1 | Monitored clock |
| monRstN | input | 1 | Active-low asynchronous reset of the divider domain |
| refClk | input | 1 | Fast reference sampling clock |
| refRstN | input | 1 | Active-low asynchronous reset of the reference domain |
| divRatio | input | DIV_W | Monitored edges per half period of the divided wave |
| expectCount | input | CNT_W | Normal number of reference cycles between transitions |
| validLen | input | VAL_W | Clean reference cycles needed to clear the alarm |
| losAlarm | output | 1 | Sticky loss-of-signal alarm, high when active |

## Verification
Two events can fall in the same reference cycle: a new loss condition and the last cycle of the validation window. When both happen, loss must win and the alarm must stay set. The bench provokes the collision by sweeping where a second input stop begins, across offsets that run up to and past the end of the window. A behavioural model built from the divider and gap rules then judges the alarm on every reference cycle.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef struct packed {
    logic valClr;
    logic valInc;
  } ctrlStrb_t;

  typedef struct packed {
    logic losCond;
    logic valFull;
  } dpStat_t;
endpackage

// File: rtl/los_clkdiv.sv
module los_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             monClk,
  input  logic             monRstN,
  input  logic [DIV_W-1:0] divRatio,
  output logic             divOut
);
  logic [DIV_W-1:0] ratioCfg;
  logic [DIV_W-1:0] cnt;
  logic             wrapNow;

  assign wrapNow = ({1'b0, cnt} + 1'b1) >= {1'b0, ratioCfg};

  // R2: toggle once per divRatio monitored edges
  always_ff @(posedge monClk or negedge monRstN) begin
    if (!monRstN) begin
      ratioCfg <= divRatio;
      cnt      <= '0;
      divOut   <= 1'b0;
    end else if (wrapNow) begin
      cnt    <= '0;
      divOut <= ~divOut;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r8_ratio_stable: assert property (@(posedge monClk) disable iff (!monRstN)
    $stable(ratioCfg));
endmodule

// File: rtl/los_datapath.sv
module los_datapath
  import los_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int VAL_W = 12
) (
  input  logic             refClk,
  input  logic             refRstN,
  input  logic             divIn,
  input  logic [CNT_W-1:0] expectCount,
  input  logic [VAL_W-1:0] validLen,
  input  ctrlStrb_t        strb,
  output dpStat_t          stat
);
  localparam int GAP_W = CNT_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = '1;

  logic [GAP_W-1:0] thresh;
  logic [VAL_W-1:0] valLast;
  logic             syncA, syncB, syncC;
  logic             edgeSeen;
  logic [GAP_W-1:0] gapCnt;
  logic [VAL_W-1:0] valCnt;

  // R8: configuration captured while reset is held
  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN) begin
      thresh  <= {expectCount, 1'b0};
      valLast <= (validLen == '0) ? '0 : validLen - 1'b1;
    end
  end

  // R3: two-flop synchronizer plus one history flop
  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= divIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign edgeSeen = syncB ^ syncC;

  // R4 / R7: saturating gap counter, starts saturated
  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN)                gapCnt <= GAP_MAX;
    else if (edgeSeen)           gapCnt <= '0;
    else if (gapCnt != GAP_MAX)  gapCnt <= gapCnt + 1'b1;
  end

  // R5 / R6: validation window counter
  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN)         valCnt <= '0;
    else if (strb.valClr) valCnt <= '0;
    else if (strb.valInc) valCnt <= valCnt + 1'b1;
  end

  assign stat.losCond = gapCnt >= thresh;
  assign stat.valFull = valCnt == valLast;

  a_r3_edge_clears_gap: assert property (@(posedge refClk) disable iff (!refRstN)
    edgeSeen |=> gapCnt == '0);
  a_r7_gap_saturates: assert property (@(posedge refClk) disable iff (!refRstN)
    (gapCnt == GAP_MAX && !edgeSeen) |=> gapCnt == GAP_MAX);
  a_r6_window_restart: assert property (@(posedge refClk) disable iff (!refRstN)
    strb.valClr |=> valCnt == '0);
  a_r8_cfg_stable: assert property (@(posedge refClk) disable iff (!refRstN)
    $stable(thresh) && $stable(valLast));
endmodule

// File: rtl/los_ctrl.sv
module los_ctrl
  import los_pkg::*;
(
  input  logic      refClk,
  input  logic      refRstN,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      alarm
);
  always_comb begin
    strb.valClr = stat.losCond || !alarm;
    strb.valInc = alarm && !stat.losCond && !stat.valFull;
  end

  // R1: alarm set out of reset; R4 sets, R5 clears
  always_ff @(posedge refClk or negedge refRstN) begin
    if (!refRstN)                   alarm <= 1'b1;
    else if (stat.losCond)          alarm <= 1'b1;
    else if (alarm && stat.valFull) alarm <= 1'b0;
  end

  a_r4_loss_sets_alarm: assert property (@(posedge refClk) disable iff (!refRstN)
    stat.losCond |=> alarm);
  a_r5_clear_after_window: assert property (@(posedge refClk) disable iff (!refRstN)
    $fell(alarm) |-> $past(stat.valFull && !stat.losCond));
  a_r5_low_stays_low: assert property (@(posedge refClk) disable iff (!refRstN)
    (!alarm && !stat.losCond) |=> !alarm);
endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 8,
  parameter int VAL_W = 12
) (
  input  logic             monClk,
  input  logic             monRstN,
  input  logic             refClk,
  input  logic             refRstN,
  input  logic [DIV_W-1:0] divRatio,
  input  logic [CNT_W-1:0] expectCount,
  input  logic [VAL_W-1:0] validLen,
  output logic             losAlarm
);
  logic      divWave;
  ctrlStrb_t strb;
  dpStat_t   stat;

  los_clkdiv #(.DIV_W(DIV_W)) u_div (
    .monClk(monClk), .monRstN(monRstN), .divRatio(divRatio), .divOut(divWave)
  );

  los_datapath #(.CNT_W(CNT_W), .VAL_W(VAL_W)) u_dp (
    .refClk(refClk), .refRstN(refRstN), .divIn(divWave),
    .expectCount(expectCount), .validLen(validLen), .strb(strb), .stat(stat)
  );

  los_ctrl u_ctrl (
    .refClk(refClk), .refRstN(refRstN), .stat(stat), .strb(strb), .alarm(losAlarm)
  );
endmodule

// File: tb/sim_los_monitor.sv
module sim_los_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int GMAX = 511;

  logic refClk = 1'b0;
  logic monRaw = 1'b0;
  logic monRun = 1'b0;
  logic monClk;
  logic monRstN = 1'b0;
  logic refRstN = 1'b0;
  logic [7:0]  divRatio = 8'd10;
  logic [7:0]  expectCount = 8'd4;
  logic [11:0] validLen = 12'd20;
  logic losAlarm;

  int checks = 0;
  int fails = 0;
  string curTag = "R1";

  always #(CLK_PERIOD/2) refClk = ~refClk;
  always #2 monRaw = ~monRaw;
  assign monClk = monRaw & monRun;

  los_monitor u0 (
    .monClk(monClk), .monRstN(monRstN), .refClk(refClk), .refRstN(refRstN),
    .divRatio(divRatio), .expectCount(expectCount), .validLen(validLen),
    .losAlarm(losAlarm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: divided wave in the monitored domain
  int  mCnt;
  int  mRatio;
  bit  mWave;
  always @(posedge monClk or negedge monRstN) begin
    if (!monRstN) begin
      mCnt   <= 0;
      mWave  <= 1'b0;
      mRatio <= (divRatio == 0) ? 1 : int'(divRatio);
    end else if (mCnt + 1 >= mRatio) begin
      mCnt  <= 0;
      mWave <= ~mWave;
    end else begin
      mCnt <= mCnt + 1;
    end
  end

  // behavioural model: reference domain
  bit samp[$];
  int gap, cleanRun, thr, need;
  bit mAlm;
  always @(posedge refClk or negedge refRstN) begin
    if (!refRstN) begin
      samp = '{1'b0, 1'b0, 1'b0};
      gap = GMAX; cleanRun = 0; mAlm = 1'b1;
      thr = 2 * int'(expectCount);
      need = (validLen == 0) ? 1 : int'(validLen);
    end else begin
      bit lossNow, sawEdge;
      lossNow = gap >= thr;
      sawEdge = samp[1] != samp[2];
      if (lossNow) begin
        mAlm = 1'b1;
        cleanRun = 0;
      end else begin
        if (cleanRun < 100000) cleanRun++;
        if (mAlm && cleanRun >= need) mAlm = 1'b0;
      end
      if (sawEdge) gap = 0;
      else if (gap < GMAX) gap++;
      void'(samp.pop_back());
      samp.push_front(mWave);
    end
  end

  always @(negedge refClk) begin
    if (!refRstN) chk(losAlarm === 1'b1, "R1", int'(losAlarm), 1);
    else chk(losAlarm === mAlm, curTag, int'(losAlarm), int'(mAlm));
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge refClk);
  endtask

  task automatic setRun(input bit v);
    @(negedge refClk);
    #1 monRun = v;
  endtask

  task automatic doReset();
    @(negedge refClk);
    #1; monRstN = 1'b0; refRstN = 1'b0;
    monRun = 1'b1;
    cyc(4);
    #1; monRstN = 1'b1; refRstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    curTag = "R1";
    doReset();
    cyc(1);
    chk(losAlarm === 1'b1, "R1", int'(losAlarm), 1);
    cyc(10);
    chk(losAlarm === 1'b1, "R1", int'(losAlarm), 1);
    curTag = "R5";
    cyc(60);
    chk(losAlarm === 1'b0, "R5", int'(losAlarm), 0);

    curTag = "R9";
    setRun(1'b0); cyc(1); setRun(1'b1);
    cyc(20);
    chk(losAlarm === 1'b0, "R9", int'(losAlarm), 0);

    curTag = "R4";
    setRun(1'b0); cyc(30);
    chk(losAlarm === 1'b1, "R4", int'(losAlarm), 1);

    curTag = "R6";
    setRun(1'b1); cyc(10);
    setRun(1'b0); cyc(15);
    setRun(1'b1); cyc(15);
    chk(losAlarm === 1'b1, "R6", int'(losAlarm), 1);
    cyc(40);
    chk(losAlarm === 1'b0, "R6", int'(losAlarm), 0);

    curTag = "R8";
    expectCount = 8'd1;
    validLen = 12'd1;
    cyc(50);
    chk(losAlarm === 1'b0, "R8", int'(losAlarm), 0);

    curTag = "R7";
    setRun(1'b0); cyc(700);
    chk(losAlarm === 1'b1, "R7", int'(losAlarm), 1);
    setRun(1'b1); cyc(60);
    chk(losAlarm === 1'b0, "R7", int'(losAlarm), 0);

    curTag = "R2";
    divRatio = 8'd5; expectCount = 8'd3; validLen = 12'd7;
    doReset();
    cyc(30);
    chk(losAlarm === 1'b0, "R2", int'(losAlarm), 0);

    curTag = "R3";
    setRun(1'b0); cyc(10);
    chk(losAlarm === 1'b1, "R3", int'(losAlarm), 1);
    setRun(1'b1); cyc(20);
    chk(losAlarm === 1'b0, "R3", int'(losAlarm), 0);

    curTag = "R6";
    for (int off = 2; off < 14; off++) begin
      setRun(1'b0); cyc(12);
      setRun(1'b1); cyc(off);
      setRun(1'b0); cyc(4);
      setRun(1'b1); cyc(30);
      chk(losAlarm === 1'b0, "R6", int'(losAlarm), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule